// File: doc/BRIEF.md
# PC Card Access Timing Generator

This block turns a requested card access time, given in nanoseconds, into three bus-clock cycle counts: address setup, strobe length and hold. It then drives one card access through those three phases in order. The cycle budget is derived from the bus clock frequency, which is a parameter. The budget is stretched by an 80% safety margin. It is kept below a bus-monitor timeout so that a slow card can never trip the bus watchdog.

A host pulses `start` with an access time and a flag that says whether the access is to I/O or to memory space. While `busy` is high, the block does two things in turn. First, a small shift-subtract divider splits the budget in sevenths. Then the sequencer raises `ph_setup`, `ph_strobe` and `ph_hold` in turn for their programmed lengths, and ends with a one-cycle `done`. The programmed counts and a clamp warning stay on the outputs until the next accepted access.

Top module: `pct_timing_gen`

## Requirements
- R1: An access time of 0 ns is replaced by `IO_DEFAULT_NS` (255) when `is_io` is 1, and by `MEM_DEFAULT_NS` (100) when `is_io` is 0.
- R2: The total budget is floor(floor(BUS_KHZ × ns / 1000) × 180 / 100000) cycles. With no clamp, `setup_cnt + strobe_cnt + hold_cnt` equals that total.
- R3: When the raw total is `BMT_LIMIT` (60) or more, the total becomes `BMT_LIMIT - 1` and `clamped` reads 1. Otherwise `clamped` reads 0.
- R4: `hold_cnt` is floor(total / 7) and `strobe_cnt` is floor(5 × total / 7).
- R5: `setup_cnt` takes whatever truncation leaves over, so it equals total − strobe − hold.
- R6: The phases run in the order setup, strobe, hold. Each strobe is high for exactly its count in cycles, and no idle cycle falls between phases.
- R7: A phase whose count is zero is skipped and costs no cycle. With all counts zero, `done` follows the divide step directly.
- R8: `done` is high for exactly one cycle, in the cycle after the last phase. `busy` is high from the cycle after an accepted start through the `done` cycle, and then falls. The counts and `clamped` are valid once `busy` is low.
- R9: A `start` that arrives while `busy` is high is ignored. The counts in flight and the sequence are unchanged, and no second access follows.
- R10: At most one of `ph_setup`, `ph_strobe`, `ph_hold` and `done` is high in any cycle. After reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start pulse for one access |
| access_ns | input | NS_W | Requested access time in ns |
| is_io | input | 1 | 1 selects I/O space, 0 selects memory space |
| setup_cnt | output | CW | Programmed setup cycles |
| strobe_cnt | output | CW | Programmed strobe cycles |
| hold_cnt | output | CW | Programmed hold cycles |
| clamped | output | 1 | Budget was limited by the bus-monitor bound |
| ph_setup | output | 1 | Setup phase active |
| ph_strobe | output | 1 | Strobe phase active |
| ph_hold | output | 1 | Hold phase active |
| done | output | 1 | One-cycle end-of-access pulse |
| busy | output | 1 | Access being computed or sequenced |

## Verification
The assertions check the following on every cycle:
- the phase strobes and `done` are mutually exclusive;
- the phase order never runs backwards;
- `done` is a single-cycle pulse;
- the outputs stay quiet while idle;
- the programmed counts sum to less than the bus-monitor bound;
- neither the divider nor the sequencer is relaunched mid-access.

Only the bench scenarios can show the arithmetic itself: the zero-time defaults, the margin and truncation, and the clamp boundary between 666 ns and 667 ns. The same holds for the exact length of each phase, for zero-length phases being skipped, and for a start issued mid-access leaving the programmed counts unchanged.

// File: rtl/pct_pkg.sv
package pct_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_SETUP,
    PH_STROBE,
    PH_HOLD,
    PH_DONE
  } pct_phase_e;
endpackage

// File: rtl/pct_budget.sv
module pct_budget #(
  parameter int NS_W           = 10,
  parameter int BUS_KHZ        = 50000,
  parameter int BMT_LIMIT      = 60,
  parameter int IO_DEFAULT_NS  = 255,
  parameter int MEM_DEFAULT_NS = 100,
  parameter int CW             = $clog2(BMT_LIMIT)
) (
  input  logic [NS_W-1:0] access_ns,
  input  logic            is_io,
  output logic [CW-1:0]   total,
  output logic            over
);
  localparam int PW = 64;

  logic [NS_W-1:0] ns_eff;
  logic [PW-1:0]   base_cyc;
  logic [PW-1:0]   raw_cyc;

  always_comb begin
    if (access_ns == '0) begin
      ns_eff = is_io ? NS_W'(IO_DEFAULT_NS) : NS_W'(MEM_DEFAULT_NS);
    end else begin
      ns_eff = access_ns;
    end
    base_cyc = (PW'(BUS_KHZ) * PW'(ns_eff)) / PW'(1000);
    raw_cyc  = (base_cyc * PW'(180)) / PW'(100000);
    over     = (raw_cyc >= PW'(BMT_LIMIT));
    total    = over ? CW'(BMT_LIMIT - 1) : CW'(raw_cyc);
  end
endmodule

// File: rtl/pct_div7.sv
module pct_div7 #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] dividend,
  output logic [W-1:0] quot,
  output logic [2:0]   rem,
  output logic         done
);
  localparam int CNTW = $clog2(W + 1);

  logic            run_q, run_n;
  logic [CNTW-1:0] cnt_q, cnt_n;
  logic [W-1:0]    work_q, work_n;
  logic [W-1:0]    quot_q, quot_n;
  logic [2:0]      rem_q, rem_n;
  logic            done_q, done_n;
  logic [3:0]      trial;
  logic            fits;

  always_comb begin
    trial  = {rem_q, work_q[W-1]};
    fits   = (trial >= 4'd7);
    run_n  = run_q;
    cnt_n  = cnt_q;
    work_n = work_q;
    quot_n = quot_q;
    rem_n  = rem_q;
    done_n = 1'b0;
    if (load) begin
      run_n  = 1'b1;
      cnt_n  = CNTW'(W);
      work_n = dividend;
      quot_n = '0;
      rem_n  = '0;
    end else if (run_q) begin
      work_n = work_q << 1;
      quot_n = {quot_q[W-2:0], fits};
      rem_n  = fits ? 3'(trial - 4'd7) : trial[2:0];
      cnt_n  = cnt_q - CNTW'(1);
      if (cnt_q == CNTW'(1)) begin
        run_n  = 1'b0;
        done_n = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      cnt_q  <= '0;
      work_q <= '0;
      quot_q <= '0;
      rem_q  <= '0;
      done_q <= 1'b0;
    end else begin
      run_q  <= run_n;
      cnt_q  <= cnt_n;
      work_q <= work_n;
      quot_q <= quot_n;
      rem_q  <= rem_n;
      done_q <= done_n;
    end
  end

  assign quot = quot_q;
  assign rem  = rem_q;
  assign done = done_q;

  AST_NO_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !run_q); // R9
  AST_REM_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (rem_q < 3'd7)); // R4
endmodule

// File: rtl/pct_phase_seq.sv
module pct_phase_seq
  import pct_pkg::*;
#(
  parameter int CW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic [CW-1:0] n_setup,
  input  logic [CW-1:0] n_strobe,
  input  logic [CW-1:0] n_hold,
  output logic          ph_setup,
  output logic          ph_strobe,
  output logic          ph_hold,
  output logic          done
);
  pct_phase_e    st_q, st_n;
  logic [CW-1:0] left_q, left_n;
  logic [CW-1:0] stb_q, stb_n;
  logic [CW-1:0] hld_q, hld_n;

  always_comb begin
    st_n   = st_q;
    left_n = left_q;
    stb_n  = stb_q;
    hld_n  = hld_q;
    case (st_q)
      PH_IDLE: begin
        if (go) begin
          stb_n = n_strobe;
          hld_n = n_hold;
          if (n_setup != '0) begin
            st_n   = PH_SETUP;
            left_n = n_setup - CW'(1);
          end else if (n_strobe != '0) begin
            st_n   = PH_STROBE;
            left_n = n_strobe - CW'(1);
          end else if (n_hold != '0) begin
            st_n   = PH_HOLD;
            left_n = n_hold - CW'(1);
          end else begin
            st_n = PH_DONE;
          end
        end
      end
      PH_SETUP: begin
        if (left_q != '0) begin
          left_n = left_q - CW'(1);
        end else if (stb_q != '0) begin
          st_n   = PH_STROBE;
          left_n = stb_q - CW'(1);
        end else if (hld_q != '0) begin
          st_n   = PH_HOLD;
          left_n = hld_q - CW'(1);
        end else begin
          st_n = PH_DONE;
        end
      end
      PH_STROBE: begin
        if (left_q != '0) begin
          left_n = left_q - CW'(1);
        end else if (hld_q != '0) begin
          st_n   = PH_HOLD;
          left_n = hld_q - CW'(1);
        end else begin
          st_n = PH_DONE;
        end
      end
      PH_HOLD: begin
        if (left_q != '0) begin
          left_n = left_q - CW'(1);
        end else begin
          st_n = PH_DONE;
        end
      end
      default: st_n = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= PH_IDLE;
      left_q <= '0;
      stb_q  <= '0;
      hld_q  <= '0;
    end else begin
      st_q   <= st_n;
      left_q <= left_n;
      stb_q  <= stb_n;
      hld_q  <= hld_n;
    end
  end

  assign ph_setup  = (st_q == PH_SETUP);
  assign ph_strobe = (st_q == PH_STROBE);
  assign ph_hold   = (st_q == PH_HOLD);
  assign done      = (st_q == PH_DONE);

  AST_GO_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> (st_q == PH_IDLE)); // R9
endmodule

// File: rtl/pct_timing_gen.sv
module pct_timing_gen #(
  parameter int NS_W           = 10,
  parameter int BUS_KHZ        = 50000,
  parameter int BMT_LIMIT      = 60,
  parameter int IO_DEFAULT_NS  = 255,
  parameter int MEM_DEFAULT_NS = 100,
  parameter int CW             = $clog2(BMT_LIMIT)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [NS_W-1:0] access_ns,
  input  logic            is_io,
  output logic [CW-1:0]   setup_cnt,
  output logic [CW-1:0]   strobe_cnt,
  output logic [CW-1:0]   hold_cnt,
  output logic            clamped,
  output logic            ph_setup,
  output logic            ph_strobe,
  output logic            ph_hold,
  output logic            done,
  output logic            busy
);
  logic [1:0]    rst_sync_q;
  logic          rst_s_n;
  logic          accept;
  logic [CW-1:0] bud_total;
  logic          bud_over;
  logic [CW-1:0] div_q;
  logic [2:0]    div_r;
  logic          div_done;
  logic [2:0]    frac5;
  logic [CW-1:0] new_strobe, new_hold, new_setup;
  logic          busy_q, busy_n;
  logic          clamp_q, clamp_n;
  logic [CW-1:0] total_q, total_n;
  logic [CW-1:0] set_q, set_n, stb_q, stb_n, hld_q, hld_n;
  logic          seq_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_s_n = rst_sync_q[1];

  assign accept = start & ~busy_q;

  pct_budget #(
    .NS_W(NS_W), .BUS_KHZ(BUS_KHZ), .BMT_LIMIT(BMT_LIMIT),
    .IO_DEFAULT_NS(IO_DEFAULT_NS), .MEM_DEFAULT_NS(MEM_DEFAULT_NS), .CW(CW)
  ) u_budget (
    .access_ns(access_ns), .is_io(is_io), .total(bud_total), .over(bud_over)
  );

  pct_div7 #(.W(CW)) u_div (
    .clk(clk), .rst_n(rst_s_n), .load(accept), .dividend(bud_total),
    .quot(div_q), .rem(div_r), .done(div_done)
  );

  always_comb begin
    case (div_r)
      3'd2:    frac5 = 3'd1;
      3'd3:    frac5 = 3'd2;
      3'd4:    frac5 = 3'd2;
      3'd5:    frac5 = 3'd3;
      3'd6:    frac5 = 3'd4;
      default: frac5 = 3'd0;
    endcase
    new_hold   = div_q;
    new_strobe = CW'((div_q << 2) + div_q) + CW'(frac5);
    new_setup  = total_q - new_hold - new_strobe;
  end

  pct_phase_seq #(.CW(CW)) u_seq (
    .clk(clk), .rst_n(rst_s_n), .go(div_done),
    .n_setup(new_setup), .n_strobe(new_strobe), .n_hold(new_hold),
    .ph_setup(ph_setup), .ph_strobe(ph_strobe), .ph_hold(ph_hold),
    .done(seq_done)
  );

  always_comb begin
    busy_n  = busy_q;
    clamp_n = clamp_q;
    total_n = total_q;
    set_n   = set_q;
    stb_n   = stb_q;
    hld_n   = hld_q;
    if (accept) begin
      busy_n  = 1'b1;
      clamp_n = bud_over;
      total_n = bud_total;
    end else if (seq_done) begin
      busy_n = 1'b0;
    end
    if (div_done) begin
      set_n = new_setup;
      stb_n = new_strobe;
      hld_n = new_hold;
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      busy_q  <= 1'b0;
      clamp_q <= 1'b0;
      total_q <= '0;
      set_q   <= '0;
      stb_q   <= '0;
      hld_q   <= '0;
    end else begin
      busy_q  <= busy_n;
      clamp_q <= clamp_n;
      total_q <= total_n;
      set_q   <= set_n;
      stb_q   <= stb_n;
      hld_q   <= hld_n;
    end
  end

  assign setup_cnt  = set_q;
  assign strobe_cnt = stb_q;
  assign hold_cnt   = hld_q;
  assign clamped    = clamp_q;
  assign done       = seq_done;
  assign busy       = busy_q;

  AST_PHASE_EXCL: assert property (@(posedge clk) disable iff (!rst_s_n)
    $onehot0({ph_setup, ph_strobe, ph_hold, seq_done})); // R10
  AST_NO_BACK_TO_SETUP: assert property (@(posedge clk) disable iff (!rst_s_n)
    ph_strobe |=> !ph_setup); // R6
  AST_HOLD_IS_LAST: assert property (@(posedge clk) disable iff (!rst_s_n)
    ph_hold |=> (!ph_setup && !ph_strobe)); // R6
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_s_n)
    seq_done |=> !seq_done); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_s_n)
    !busy_q |-> !(ph_setup || ph_strobe || ph_hold || seq_done)); // R8
  AST_SUM_BOUND: assert property (@(posedge clk) disable iff (!rst_s_n)
    !busy_q |-> ((8'(set_q) + 8'(stb_q) + 8'(hld_q)) < 8'(BMT_LIMIT))); // R3
endmodule

// File: tb/pct_timing_gen_test.sv
`timescale 1ns/1ps
module pct_timing_gen_test;
  localparam int NS_W = 10;
  localparam int CW   = 6;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            start = 1'b0;
  logic [NS_W-1:0] access_ns = '0;
  logic            is_io = 1'b0;
  logic [CW-1:0]   setup_cnt, strobe_cnt, hold_cnt;
  logic            clamped, ph_setup, ph_strobe, ph_hold, done, busy;

  int n_checks = 0;
  int n_fails  = 0;

  always #2.5 clk = ~clk;

  pct_timing_gen uut (
    .clk(clk), .rst_n(rst_n), .start(start), .access_ns(access_ns), .is_io(is_io),
    .setup_cnt(setup_cnt), .strobe_cnt(strobe_cnt), .hold_cnt(hold_cnt),
    .clamped(clamped), .ph_setup(ph_setup), .ph_strobe(ph_strobe),
    .ph_hold(ph_hold), .done(done), .busy(busy)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic void model(input int ns, input bit io,
                                output int s, output int st, output int h, output bit cl);
    longint n, base, tot;
    n    = (ns == 0) ? (io ? 255 : 100) : ns;
    base = (longint'(50000) * n) / 1000;
    tot  = (base * 180) / 100000;
    cl   = (tot >= 60);
    if (cl) tot = 59;
    h  = int'(tot / 7);
    st = int'((tot * 5) / 7);
    s  = int'(tot) - h - st;
  endfunction

  task automatic run_access(input int ns, input bit io, input int inj_at, input int inj_ns);
    int es, est, eh;
    bit ecl;
    int cs, cst, ch, last, ndone;
    bit started, order_bad, gap_bad, excl_bad, busy_bad;
    model(ns, io, es, est, eh, ecl);
    cs = 0; cst = 0; ch = 0; last = 0; ndone = 0;
    started = 0; order_bad = 0; gap_bad = 0; excl_bad = 0; busy_bad = 0;
    @(negedge clk);
    access_ns = NS_W'(ns);
    is_io = io;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int cyc = 0; cyc < 400; cyc++) begin
      int cur;
      cur = ph_setup ? 1 : ph_strobe ? 2 : ph_hold ? 3 : 0;
      if ((32'(ph_setup) + 32'(ph_strobe) + 32'(ph_hold) + 32'(done)) > 1) excl_bad = 1;
      if (!busy) busy_bad = 1;
      if (cur != 0) begin
        if (cur < last) order_bad = 1;
        started = 1;
        last = cur;
      end else if (started && !done) begin
        gap_bad = 1;
      end
      if (ph_setup) cs++;
      if (ph_strobe) cst++;
      if (ph_hold) ch++;
      if (done) begin
        ndone++;
        break;
      end
      if (cyc == inj_at) begin
        access_ns = NS_W'(inj_ns);
        is_io = ~io;
        start = 1'b1;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
    end
    start = 1'b0;
    chk(ndone == 1, "R8 done seen", ndone, 1);
    chk(!busy_bad, "R8 busy held during access", int'(busy_bad), 0);
    chk(!excl_bad, "R10 phase exclusivity", int'(excl_bad), 0);
    chk(!order_bad && !gap_bad, "R6 order and no gaps", int'(order_bad) + int'(gap_bad), 0);
    chk(cs == es, "R6 setup cycles", cs, es);
    chk(cst == est, "R6 strobe cycles", cst, est);
    chk(ch == eh, "R6 hold cycles", ch, eh);
    @(negedge clk);
    chk(busy == 1'b0, "R8 busy falls after done", int'(busy), 0);
    chk(int'(hold_cnt) == eh, "R4 hold count", int'(hold_cnt), eh);
    chk(int'(strobe_cnt) == est, "R4 strobe count", int'(strobe_cnt), est);
    chk(int'(setup_cnt) == es, "R5 setup count", int'(setup_cnt), es);
    chk(int'(setup_cnt) + int'(strobe_cnt) + int'(hold_cnt) == es + est + eh,
        "R2 total budget", int'(setup_cnt) + int'(strobe_cnt) + int'(hold_cnt), es + est + eh);
    chk(clamped == ecl, "R3 clamp flag", int'(clamped), int'(ecl));
    if (es == 0 || est == 0 || eh == 0)
      chk(cs + cst + ch == es + est + eh, "R7 zero phases skipped", cs + cst + ch, es + est + eh);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    int s, st, h;
    bit cl;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(busy == 0 && done == 0 && ph_setup == 0 && ph_strobe == 0 && ph_hold == 0,
        "R10 reset outputs", int'(busy) + int'(done), 0);
    chk(setup_cnt == 0 && strobe_cnt == 0 && hold_cnt == 0 && clamped == 0,
        "R10 reset counts", int'(setup_cnt) + int'(strobe_cnt) + int'(hold_cnt), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: zero-time defaults (255 ns gives 22 cycles, 100 ns gives 9)
    run_access(0, 1'b1, -1, 0);
    chk(int'(setup_cnt) + int'(strobe_cnt) + int'(hold_cnt) == 22, "R1 io default",
        int'(setup_cnt) + int'(strobe_cnt) + int'(hold_cnt), 22);
    run_access(0, 1'b0, -1, 0);
    chk(int'(setup_cnt) + int'(strobe_cnt) + int'(hold_cnt) == 9, "R1 mem default",
        int'(setup_cnt) + int'(strobe_cnt) + int'(hold_cnt), 9);
    // R7: all-zero, setup-only and hold-zero budgets
    run_access(1, 1'b0, -1, 0);
    run_access(20, 1'b0, -1, 0);
    run_access(56, 1'b1, -1, 0);
    run_access(140, 1'b0, -1, 0);
    // R3: clamp boundary
    run_access(666, 1'b0, -1, 0);
    chk(clamped == 1'b0, "R3 below limit", int'(clamped), 0);
    run_access(667, 1'b0, -1, 0);
    chk(clamped == 1'b1, "R3 at limit", int'(clamped), 1);
    run_access(1023, 1'b1, -1, 0);
    // R9: start during access is ignored
    run_access(300, 1'b0, 3, 1000);
    run_access(500, 1'b1, 15, 0);
    repeat (20) begin
      @(negedge clk);
      chk(!(busy || ph_setup || ph_strobe || ph_hold || done), "R9 no second access",
          int'(busy), 0);
    end
    model(500, 1'b1, s, st, h, cl);
    chk(int'(setup_cnt) == s && int'(strobe_cnt) == st, "R9 counts kept",
        int'(setup_cnt), s);

    for (int i = 0; i < 40; i++) begin
      int ns;
      bit io;
      ns = int'($urandom % 1024);
      io = bit'($urandom % 2);
      if (i % 5 == 4) run_access(ns, io, int'($urandom % 12), int'($urandom % 1024));
      else run_access(ns, io, -1, 0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule